// File: doc/BRIEF.md
# Armed Software Reset Controller

This block decodes a write-only command register and a read-only status register on a simple host register bus. A single write to the command register can raise several one-cycle clear strobes at once. These strobes go to neighbouring datapaths: the alarm thresholds and their flags, the averaging and hysteresis history, a FIFO, and the DAC input and output registers. The datapaths themselves are outside this block, which only produces the strobes.

A full device reset needs two writes in a fixed order. The first write arms the sequence and the second write fires it. When the reset fires, the block drives a reset-request output for a fixed number of cycles. The status register shows the live state of an external calculation-busy signal. It also shows a sticky restart flag, which is set by a full reset or by a watchdog event and clears when the host reads it.

Command register bits: bit 0 fire, bit 1 arm, bit 2 alarm clear, bit 3 average clear, bit 4 FIFO clear, bit 5 DAC reset, bit 6 reserved. Status register bits: bit 0 busy, bit 1 restart, and all other bits read as 0.

Top module: `srst_ctrl`

## Requirements
- R1: Bits 15 down to 6 of a command write have no effect on any output or on the arm state.
- R2: A command write raises alarm_clr, avg_clr, fifo_clr and dac_clr from bits 2, 3, 4 and 5 respectively. Each strobe is high for exactly the one cycle after the write is sampled.
- R3: A command write arms the sequence only when bit 1 is 1 and bit 0 is 0. A word with both bits set does not arm.
- R4: Bit 0 starts a full reset only if the command write directly before it left the sequence armed. Any command write that neither arms nor fires disarms the sequence.
- R5: A full reset holds rst_req high for RST_CYCLES cycles (16 by default), starting the cycle after the fire write. The reset also disarms, so a second fire write without a new arm does nothing.
- R6: The restart flag (status bit 1) is set by a full reset or by a one-cycle wdog_evt pulse. After a status read returns it, the flag reads as 0.
- R7: The restart flag is 0 after the rst input, and rst_req does not clear it.
- R8: Status bit 0 equals busy_in at the read, and status bits 15 down to 2 read as 0. FIFO-clear and DAC-reset writes do not change the busy bit.
- R9: Writes to any address other than CLR_ADDR (0) produce no strobe and do not disarm the sequence. A read returns its data one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| rd_en | input | 1 | Register read enable |
| addr | input | ADDR_W | Register address (command at CLR_ADDR, status at STAT_ADDR) |
| wdata | input | DATA_W | Write data |
| busy_in | input | 1 | Calculation-busy signal from the datapath |
| wdog_evt | input | 1 | One-cycle watchdog reset event |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| alarm_clr | output | 1 | Alarm threshold and flag clear strobe |
| avg_clr | output | 1 | Averaging/hysteresis clear and reacquire strobe |
| fifo_clr | output | 1 | FIFO clear strobe |
| dac_clr | output | 1 | DAC register clear strobe |
| rst_req | output | 1 | Full reset request |

## Verification
The bench builds the block with its defaults: 16-bit data, 2-bit address and a 16-cycle reset request. With a 7-bit command field, all 128 command codes can be swept twice. The first sweep starts from the disarmed state, with varying junk in the upper bits. The second sweep uses each code as the first write of an arm-then-fire pair, so every arm and fire combination and its effect on the restart flag is covered. The 16-cycle reset request is short enough to count cycle by cycle on every firing.

// File: rtl/srst_pkg.sv
package srst_pkg;
    localparam int CMD_BITS    = 6;
    localparam int FIRE_BIT    = 0;
    localparam int ARM_BIT     = 1;
    localparam int STROBE_LSB  = 2;
    localparam int NUM_STROBES = 4;
    localparam int STAT_BUSY_BIT    = 0;
    localparam int STAT_RESTART_BIT = 1;

    typedef struct packed {
        logic [NUM_STROBES-1:0] clears;
        logic                   arm;
        logic                   fire;
    } clr_cmd_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } arm_state_e;

    function automatic clr_cmd_t decode_clr(input logic [CMD_BITS-1:0] w);
        clr_cmd_t c;
        c.fire   = w[FIRE_BIT];
        c.arm    = w[ARM_BIT];
        c.clears = w[STROBE_LSB +: NUM_STROBES];
        return c;
    endfunction
endpackage

// File: rtl/srst_cmd_decode.sv
module srst_cmd_decode
    import srst_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 2,
    parameter int CLR_ADDR = 0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cmd_valid,
    output clr_cmd_t          cmd
);
    logic unused_hi_bits;

    assign cmd_valid      = wr_en && (addr == ADDR_W'(CLR_ADDR));
    assign cmd            = decode_clr(wdata[CMD_BITS-1:0]);
    assign unused_hi_bits = ^wdata[DATA_W-1:CMD_BITS];
endmodule

// File: rtl/srst_strobe_gen.sv
module srst_strobe_gen #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_valid,
    input  logic [N-1:0] clears,
    output logic [N-1:0] strobes
);
    for (genvar i = 0; i < N; i++) begin : g_strobe
        always_ff @(posedge clk) begin
            if (rst) strobes[i] <= 1'b0;
            else     strobes[i] <= cmd_valid && clears[i];
        end
    end
endmodule

// File: rtl/srst_arm_seq.sv
module srst_arm_seq
    import srst_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  clr_cmd_t cmd,
    output logic     rst_req,
    output logic     fire_evt
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    arm_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign fire_evt = cmd_valid && cmd.fire && (state_q == SEQ_ARMED);
    assign rst_req  = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            if (cmd_valid) begin
                if (!fire_evt && cmd.arm && !cmd.fire) state_q <= SEQ_ARMED;
                else                                   state_q <= SEQ_IDLE;
            end
            if (fire_evt)          cnt_q <= CNT_W'(RST_CYCLES);
            else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R3
    arm_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.arm && cmd.fire && state_q == SEQ_IDLE) |=> (state_q == SEQ_IDLE));

    // R4
    fire_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(state_q == SEQ_ARMED));

    // R5
    fire_disarms_chk: assert property (@(posedge clk) disable iff (rst)
        fire_evt |=> (state_q == SEQ_IDLE));
endmodule

// File: rtl/srst_status.sv
module srst_status
    import srst_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_in,
    input  logic              set_evt,
    output logic [DATA_W-1:0] rdata
);
    logic              restart_q;
    logic              rd_hit;
    logic [DATA_W-1:0] status_word;

    assign rd_hit = rd_en && (addr == ADDR_W'(STAT_ADDR));

    always_comb begin
        status_word                   = '0;
        status_word[STAT_BUSY_BIT]    = busy_in;
        status_word[STAT_RESTART_BIT] = restart_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            restart_q <= 1'b0;
            rdata     <= '0;
        end else begin
            if (set_evt)     restart_q <= 1'b1;
            else if (rd_hit) restart_q <= 1'b0;
            if (rd_en)       rdata <= rd_hit ? status_word : '0;
        end
    end

    // R6
    restart_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && !set_evt) |=> !restart_q);

    // R6
    restart_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> restart_q);
endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
    import srst_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 2,
    parameter int CLR_ADDR   = 0,
    parameter int STAT_ADDR  = 1,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy_in,
    input  logic              wdog_evt,
    output logic [DATA_W-1:0] rdata,
    output logic              alarm_clr,
    output logic              avg_clr,
    output logic              fifo_clr,
    output logic              dac_clr,
    output logic              rst_req
);
    logic                   cmd_valid;
    clr_cmd_t               cmd;
    logic [NUM_STROBES-1:0] strobes;
    logic                   fire_evt;

    srst_cmd_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLR_ADDR(CLR_ADDR)) u_dec (
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .cmd_valid(cmd_valid), .cmd(cmd)
    );

    srst_strobe_gen #(.N(NUM_STROBES)) u_strb (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .clears(cmd.clears), .strobes(strobes)
    );

    srst_arm_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
        .rst_req(rst_req), .fire_evt(fire_evt)
    );

    srst_status #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_stat (
        .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .busy_in(busy_in),
        .set_evt(fire_evt || wdog_evt), .rdata(rdata)
    );

    assign alarm_clr = strobes[0];
    assign avg_clr   = strobes[1];
    assign fifo_clr  = strobes[2];
    assign dac_clr   = strobes[3];

    // R2
    alarm_origin_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_clr |-> $past(wr_en && addr == ADDR_W'(CLR_ADDR) && wdata[2]));

    // R9
    dac_origin_chk: assert property (@(posedge clk) disable iff (rst)
        dac_clr |-> $past(wr_en && addr == ADDR_W'(CLR_ADDR) && wdata[5]));
endmodule

// File: tb/srst_ctrl_bench.sv
module srst_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, busy_in = 1'b0, wdog_evt = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        alarm_clr, avg_clr, fifo_clr, dac_clr, rst_req;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    srst_ctrl u_srst_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .busy_in(busy_in), .wdog_evt(wdog_evt), .rdata(rdata), .alarm_clr(alarm_clr),
        .avg_clr(avg_clr), .fifo_clr(fifo_clr), .dac_clr(dac_clr), .rst_req(rst_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(output logic [15:0] d);
        rd_en = 1'b1; addr = 2'd1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    function automatic logic [3:0] strb();
        return {dac_clr, fifo_clr, avg_clr, alarm_clr};
    endfunction

    task automatic count_req(output int n);
        n = 0;
        while (rst_req && n < 64) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [15:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(d);
        chk(d == 16'h0000, "R7 restart clear after reset", d, 0);

        // R1 R2 R4: every command code from disarmed, junk in upper bits
        for (int v = 0; v < 128; v++) begin
            logic [15:0] w;
            w = {9'((v * 37 + 11) & 9'h1FF), 7'(v)};
            wr(2'd0, w);
            chk(strb() == 4'(v >> 2), "R1 R2 strobes", strb(), (v >> 2) & 15);
            chk(!rst_req, "R4 no fire when disarmed", rst_req, 0);
            @(negedge clk);
            chk(strb() == 4'h0, "R2 single-cycle strobe", strb(), 0);
            wr(2'd0, 16'h0000);
        end

        // R3 R4 R5 R6: each code as first write, then a fire write
        for (int v = 0; v < 128; v++) begin
            bit exp_fire;
            exp_fire = ((v & 3) == 2);
            wr(2'd0, 16'h0000);
            wr(2'd0, {9'((v * 53 + 5) & 9'h1FF), 7'(v)});
            wr(2'd0, 16'h0001);
            count_req(n);
            chk(n == (exp_fire ? 16 : 0), "R3 R5 reset length", n, exp_fire ? 16 : 0);
            rd(d);
            chk(d[1] == exp_fire, "R6 R7 restart after fire", d, exp_fire);
            rd(d);
            chk(d == 16'h0000, "R6 restart cleared by read", d, 0);
        end

        // R5: fire again without re-arm
        wr(2'd0, 16'h0002); wr(2'd0, 16'h0001);
        count_req(n);
        chk(n == 16, "R5 armed fire", n, 16);
        wr(2'd0, 16'h0001);
        chk(!rst_req, "R5 fire after reset disarmed", rst_req, 0);
        rd(d);

        // R9: write to other address neither strobes nor disarms
        wr(2'd0, 16'h0002);
        wr(2'd2, 16'h003C);
        chk(strb() == 4'h0, "R9 other address no strobe", strb(), 0);
        wr(2'd0, 16'h0001);
        count_req(n);
        chk(n == 16, "R9 arm kept across other address", n, 16);
        rd(d);

        // R4: disarm by a plain clear write
        wr(2'd0, 16'h0002); wr(2'd0, 16'h0010); wr(2'd0, 16'h0001);
        chk(!rst_req, "R4 disarm by intervening write", rst_req, 0);

        // R8: busy mirror and zero upper bits
        busy_in = 1'b1;
        rd(d);
        chk(d == 16'h0001, "R8 busy bit", d, 1);
        busy_in = 1'b0;
        wr(2'd0, 16'h0030);
        rd(d);
        chk(d == 16'h0000, "R8 fifo/dac leave busy", d, 0);

        // R6: watchdog sets restart
        wdog_evt = 1'b1; @(negedge clk); wdog_evt = 1'b0;
        busy_in = 1'b1;
        rd(d);
        chk(d == 16'h0003, "R6 watchdog restart", d, 3);
        busy_in = 1'b0;
        rd(d);
        chk(d == 16'h0000, "R6 restart clears after read", d, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule